// File: doc/BRIEF.md
# Bit-Serial Dual Accumulator

This unit holds two word-length accumulators, A and B. Each word is processed one bit per clock, least significant bit first, over a word period of exactly `W` clocks. A start strobe marks the clock that carries bit 0. A set of control bits, captured with the strobe, decides four things for that word: which accumulator receives the result, whether its old contents are discarded, whether the incoming value is added or subtracted, and whether both registers move one place left or right.

Two operand streams, one from a slow store and one from a fast store, are first summed by a serial pre-adder. When the destination is B, that sum can be raised by one unit in the least significant place. A second serial adder then adds the pre-adder result to, or subtracts it from, the destination. During the word, the old contents of both accumulators stream out on serial pins so that a surrounding store can write them away. Between words both registers hold their values, and their parallel contents are always visible.

A shift is made by reading each recirculating word one bit-time early or one bit-time late. When clearing is not requested, the two registers act as one double-length register with A as the upper half.

Top module: `dual_acc_serial`

## Requirements
- R1: While `rst_ni` is low, both accumulators are zero and both serial outputs are 0.
- R2: A word begins in the clock where `word_start_i` is high, and its bit i is presented in the i-th clock after that one. The control inputs are taken only in that first clock; changing them later in the word has no effect. Both accumulators hold their values in every clock that belongs to no word.
- R3: With `clr_i`, `sub_i`, `shl_i` and `shr_i` low, the destination becomes its old value plus the slow operand plus the fast operand, modulo 2^W. The destination is B when `dest_b_i` is 1 and A when it is 0.
- R4: With `sub_i` high, the pre-adder result is subtracted from the destination instead of added, modulo 2^W.
- R5: With `clr_i` high, the old destination value is replaced by zero before the accumulate step.
- R6: `inc_i` adds 1 to the pre-adder sum when `dest_b_i` is 1, and has no effect when `dest_b_i` is 0.
- R7: `shl_i` without `clr_i` shifts {A,B} left by one place as a 2W-bit value. B's top bit enters bit 0 of A, a 0 enters bit 0 of B, and the accumulate step then acts on the shifted destination.
- R8: `shr_i` without `clr_i` shifts {A,B} right by one place. A's top bit is copied into itself (arithmetic shift), and A's bit 0 enters the top bit of B.
- R9: With `clr_i` high, no bit passes between the registers. A left shift fills bit 0 of each register with 0, a right shift fills the top of B with 0, and A's top bit is still copied into itself on a right shift.
- R10: The accumulator that is not the destination ends the word holding its old value after the shift selected for that word.
- R11: With `dest_b_i`, `clr_i`, `sub_i` and `inc_i` all high and both operands zero, B ends the word holding all ones (−1).
- R12: During bit i of a word, `a_bit_o` and `b_bit_o` carry bit i of A and B as they stood before the word.
- R13: When `shl_i` and `shr_i` are both high, the left shift is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_start_i | input | 1 | High in the clock that carries bit 0 of a word |
| dest_b_i | input | 1 | 1 sends the result to B, 0 sends it to A |
| clr_i | input | 1 | Discard the old destination value and break the coupling between registers |
| sub_i | input | 1 | Subtract the pre-adder result |
| inc_i | input | 1 | Add one unit to the pre-adder sum (destination B only) |
| shl_i | input | 1 | Shift one place left |
| shr_i | input | 1 | Shift one place right |
| slow_bit_i | input | 1 | Serial slow-store operand, LSB first |
| fast_bit_i | input | 1 | Serial fast-store operand, LSB first |
| a_bit_o | output | 1 | Serial old contents of A |
| b_bit_o | output | 1 | Serial old contents of B |
| a_word_o | output | W | Parallel contents of A |
| b_word_o | output | W | Parallel contents of B |

## Verification
The hardest case to reach from the ports is a shift where the crossing bit matters. This needs an edge bit of the register that is not the destination to be set, together with a destination value and operand whose serial carries run through the shifted bit position. The bench reaches it by loading A and B with chosen or pseudo-random values through clear-and-add words. It then sweeps every combination of the six control bits, including both shift bits high, over several operand patterns on a narrow 8-bit configuration. It also scrambles the control pins after the first bit of every word and inserts idle gaps with active-looking inputs.

// File: rtl/dacc_pkg.sv
`timescale 1ns/1ps
package dacc_pkg;
  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2
  } shift_e;

  typedef struct packed {
    logic   dest_b;
    logic   clr;
    logic   sub;
    logic   inc;
    shift_e sh;
  } ctl_t;
endpackage

// File: rtl/dacc_word_timer.sv
`timescale 1ns/1ps
module dacc_word_timer #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic first_o,
  output logic last_o,
  output logic active_o
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign first_o  = start_i;
  assign active_o = start_i | busy_q;
  assign last_o   = busy_q && !start_i && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/dacc_serial_adder.sv
`timescale 1ns/1ps
module dacc_serial_adder (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic first_i,
  input  logic cin_i,
  input  logic x_i,
  input  logic y_i,
  output logic s_o
);
  logic c_q;
  logic c;

  // carry-in for bit 0 comes from cin_i, later bits from the flop
  assign c   = first_i ? cin_i : c_q;
  assign s_o = x_i ^ y_i ^ c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   c_q <= 1'b0;
    else if (en_i) c_q <= (x_i & y_i) | (x_i & c) | (y_i & c);
  end
endmodule

// File: rtl/dacc_shift_tap.sv
`timescale 1ns/1ps
module dacc_shift_tap
  import dacc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   first_i,
  input  logic   last_i,
  input  shift_e mode_i,
  input  logic   cur_i,
  input  logic   nxt_i,
  input  logic   fill_l_i,
  input  logic   fill_r_i,
  output logic   bit_o
);
  logic prev_q;

  // left: one bit-time late; right: one bit-time early
  always_comb begin
    unique case (mode_i)
      SH_LEFT:  bit_o = first_i ? fill_l_i : prev_q;
      SH_RIGHT: bit_o = last_i  ? fill_r_i : nxt_i;
      default:  bit_o = cur_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prev_q <= 1'b0;
    else if (en_i) prev_q <= cur_i;
  end
endmodule

// File: rtl/dual_acc_serial.sv
`timescale 1ns/1ps
module dual_acc_serial
  import dacc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         word_start_i,
  input  logic         dest_b_i,
  input  logic         clr_i,
  input  logic         sub_i,
  input  logic         inc_i,
  input  logic         shl_i,
  input  logic         shr_i,
  input  logic         slow_bit_i,
  input  logic         fast_bit_i,
  output logic         a_bit_o,
  output logic         b_bit_o,
  output logic [W-1:0] a_word_o,
  output logic [W-1:0] b_word_o
);
  logic first, last, active;
  ctl_t ctl_in, ctl_q, ctl;
  logic [W-1:0] a_q, b_q;
  logic a0_q;
  logic coupled;
  logic a_sh, b_sh, dst_sh, base, pre, acc;
  logic new_a, new_b;

  dacc_word_timer #(.W(W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (word_start_i),
    .first_o  (first),
    .last_o   (last),
    .active_o (active)
  );

  always_comb begin
    ctl_in.dest_b = dest_b_i;
    ctl_in.clr    = clr_i;
    ctl_in.sub    = sub_i;
    ctl_in.inc    = inc_i;
    ctl_in.sh     = shl_i ? SH_LEFT : (shr_i ? SH_RIGHT : SH_NONE);
  end

  assign ctl     = first ? ctl_in : ctl_q;
  assign coupled = !ctl.clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctl_q <= '0;
    else if (first) ctl_q <= ctl_in;
  end

  dacc_shift_tap u_tap_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (active),
    .first_i  (first),
    .last_i   (last),
    .mode_i   (ctl.sh),
    .cur_i    (a_q[0]),
    .nxt_i    (a_q[1]),
    .fill_l_i (coupled & b_q[W-1]),
    .fill_r_i (a_q[0]),
    .bit_o    (a_sh)
  );

  dacc_shift_tap u_tap_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (active),
    .first_i  (first),
    .last_i   (last),
    .mode_i   (ctl.sh),
    .cur_i    (b_q[0]),
    .nxt_i    (b_q[1]),
    .fill_l_i (1'b0),
    .fill_r_i (coupled & a0_q),
    .bit_o    (b_sh)
  );

  dacc_serial_adder u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (active),
    .first_i (first),
    .cin_i   (ctl.inc & ctl.dest_b),
    .x_i     (slow_bit_i),
    .y_i     (fast_bit_i),
    .s_o     (pre)
  );

  assign dst_sh = ctl.dest_b ? b_sh : a_sh;
  assign base   = ctl.clr ? 1'b0 : dst_sh;

  dacc_serial_adder u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (active),
    .first_i (first),
    .cin_i   (ctl.sub),
    .x_i     (base),
    .y_i     (pre ^ ctl.sub),
    .s_o     (acc)
  );

  assign new_a = ctl.dest_b ? a_sh : acc;
  assign new_b = ctl.dest_b ? acc  : b_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      b_q  <= '0;
      a0_q <= 1'b0;
    end else if (active) begin
      a_q <= {new_a, a_q[W-1:1]};
      b_q <= {new_b, b_q[W-1:1]};
      if (first) a0_q <= a_q[0];
    end
  end

  assign a_bit_o  = a_q[0];
  assign b_bit_o  = b_q[0];
  assign a_word_o = a_q;
  assign b_word_o = b_q;
endmodule

// File: rtl/dual_acc_serial_chk.sv
`timescale 1ns/1ps
module dual_acc_serial_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         word_start_i,
  input logic         dest_b_i,
  input logic         clr_i,
  input logic         sub_i,
  input logic         inc_i,
  input logic         shl_i,
  input logic         shr_i,
  input logic         slow_bit_i,
  input logic         fast_bit_i,
  input logic [W-1:0] a_word_o,
  input logic [W-1:0] b_word_o
);
  localparam int KW = $clog2(W + 1);

  logic [KW-1:0] cnt_q;
  logic [W-1:0]  a_cap, b_cap;
  logic          db_q, clr_q, sub_q, inc_q, shl_q, shr_q, zero_q;
  logic          done;

  assign done = (cnt_q == KW'(W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      a_cap  <= '0;
      b_cap  <= '0;
      {db_q, clr_q, sub_q, inc_q, shl_q, shr_q, zero_q} <= '0;
    end else if (word_start_i) begin
      cnt_q  <= KW'(1);
      a_cap  <= a_word_o;
      b_cap  <= b_word_o;
      {db_q, clr_q, sub_q, inc_q, shl_q, shr_q} <= {dest_b_i, clr_i, sub_i, inc_i, shl_i, shr_i};
      zero_q <= !slow_bit_i && !fast_bit_i;
    end else if (done) begin
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q + KW'(1);
      zero_q <= zero_q && !slow_bit_i && !fast_bit_i;
    end
  end

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !word_start_i) |=> ($stable(a_word_o) && $stable(b_word_o)));

  a_r11_minus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && db_q && clr_q && sub_q && inc_q && zero_q) |-> (b_word_o == '1));

  a_r9_left_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && db_q && clr_q && shl_q) |-> (a_word_o == {a_cap[W-2:0], 1'b0}));

  a_r8_right_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && db_q && shr_q && !shl_q) |-> (a_word_o == {a_cap[W-1], a_cap[W-1:1]}));

  a_r10_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && db_q && !shl_q && !shr_q) |-> (a_word_o == a_cap));

  a_r10_hold_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !db_q && !shl_q && !shr_q) |-> (b_word_o == b_cap));
endmodule

bind dual_acc_serial dual_acc_serial_chk #(.W(W)) u_chk (.*);

// File: tb/tb_dual_acc_serial.sv
`timescale 1ns/1ps
module tb_dual_acc_serial;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ws = 1'b0, db = 1'b0, cl = 1'b0, sb = 1'b0, ic = 1'b0, sl = 1'b0, sr = 1'b0;
  logic sbit = 1'b0, fbit = 1'b0;
  logic a_bit, b_bit;
  logic [W-1:0] aw, bw;
  logic [W-1:0] ma = '0, mb = '0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dual_acc_serial #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_start_i(ws), .dest_b_i(db), .clr_i(cl),
    .sub_i(sb), .inc_i(ic), .shl_i(sl), .shr_i(sr), .slow_bit_i(sbit), .fast_bit_i(fbit),
    .a_bit_o(a_bit), .b_bit_o(b_bit), .a_word_o(aw), .b_word_o(bw)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] model(input logic [W-1:0] a, b, s, f,
                                           input logic d, c, u, q, l, r);
    logic [W-1:0] as_, bs_, pre, base, res;
    if (l) begin
      as_ = {a[W-2:0], (!c) & b[W-1]};
      bs_ = {b[W-2:0], 1'b0};
    end else if (r) begin
      as_ = {a[W-1], a[W-1:1]};
      bs_ = {(!c) & a[0], b[W-1:1]};
    end else begin
      as_ = a;
      bs_ = b;
    end
    pre  = s + f + W'(q && d);
    base = c ? '0 : (d ? bs_ : as_);
    res  = u ? base - pre : base + pre;
    return d ? {as_, res} : {res, bs_};
  endfunction

  function automatic string tag_of(input logic d, c, u, q, l, r);
    if (l && r)       return "R13";
    if (c && (l || r)) return "R9";
    if (l)            return "R7";
    if (r)            return "R8";
    if (c && u && q && d) return "R11";
    if (c)            return "R5";
    if (u)            return "R4";
    if (q)            return "R6";
    return "R3";
  endfunction

  task automatic run_word(input logic d, c, u, q, l, r, input logic [W-1:0] so, fo);
    logic [W-1:0] sa, sbv, ea, eb;
    string tag;
    {ea, eb} = model(ma, mb, so, fo, d, c, u, q, l, r);
    tag = tag_of(d, c, u, q, l, r);
    for (int i = 0; i < W; i++) begin
      ws = (i == 0);
      if (i == 0) {db, cl, sb, ic, sl, sr} = {d, c, u, q, l, r};
      else        {db, cl, sb, ic, sl, sr} = 6'($urandom);  // R2: ignored mid-word
      sbit = so[i];
      fbit = fo[i];
      sa[i]  = a_bit;
      sbv[i] = b_bit;
      @(negedge clk);
    end
    ws = 1'b0;
    chk("R12 serial A", sa, ma);
    chk("R12 serial B", sbv, mb);
    chk(d ? "R10 A" : {tag, " A"}, aw, ea);
    chk(d ? {tag, " B"} : "R10 B", bw, eb);
    ma = ea;
    mb = eb;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      ws = 1'b0;
      {db, cl, sb, ic, sl, sr, sbit, fbit} = 8'($urandom);
      @(negedge clk);
      chk("R2 idle A", aw, ma);
      chk("R2 idle B", bw, mb);
    end
  endtask

  task automatic load(input logic [W-1:0] va, vb);
    run_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, va, '0);
    run_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, vb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 A word", aw, '0);
    chk("R1 B word", bw, '0);
    chk("R1 serial", W'({a_bit, b_bit}), '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed corners
    load(8'hA5, 8'h81);
    run_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);     // R7 crossing B->A
    load(8'h93, 8'h40);
    run_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0, '0);     // R8 sign + A0->B
    load(8'h7F, 8'hFF);
    run_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, '0);  // R9 no crossing
    run_word(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0);     // R11 + shift A
    chk("R11 B all ones", bw, '1);
    run_word(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 8'h01); // R6 no inc on A
    run_word(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h01); // R13
    idle(4);

    for (int c = 0; c < 64; c++) begin
      logic [5:0] k;
      k = 6'(c);
      load(8'($urandom), 8'($urandom));
      run_word(k[0], k[1], k[2], k[3], k[4], k[5], '0, '0);
      run_word(k[0], k[1], k[2], k[3], k[4], k[5], '1, '0);
      run_word(k[0], k[1], k[2], k[3], k[4], k[5], 8'h80, 8'h80);
      run_word(k[0], k[1], k[2], k[3], k[4], k[5], '1, '1);
      run_word(k[0], k[1], k[2], k[3], k[4], k[5], 8'($urandom), 8'($urandom));
      run_word(k[0], k[1], k[2], k[3], k[4], k[5], 8'($urandom), 8'($urandom));
      idle(2);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule